// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent down-counters that share one 32-bit register bus. Each counter has a 256-byte register window. The window holds a reload limit, the live count, a control byte, an interrupt clear command, and raw and masked interrupt status. A counter advances only in a cycle where its tick-enable input is high. The surrounding logic drives that input from the bus clock for channel 0 and from a slower reference for channels 1 and 2. A programmable prescaler can divide the tick by 16 or by 256 before it reaches the counter.

The control byte sets what a channel does when it counts down to zero. It can reload from the limit (periodic), wrap to all ones in 16-bit or 32-bit width (free-running), or stop at zero (one-shot). Each channel drives one interrupt line. The interrupt controller receives channel n on its line 5+n.

A background load changes the limit without disturbing the count in progress. Software uses it to retune the next period without a glitch.

Top module: `tri_interval_timer`

## Requirements
- R1: Control bit 7 enables the channel. While the bit is clear, ticks are ignored and the count holds.
- R2: When an enabled channel steps from a count of zero and is not one-shot, the next count depends on control bit 6. With bit 6 set (periodic), the limit is loaded. With bit 6 clear (free-running), the count wraps to 0xFFFFFFFF if control bit 1 is set, or to 0x0000FFFF if it is clear.
- R3: Control bits 3:2 set the tick divider. The value 01 divides by 16, 10 divides by 256, and 00 or 11 divide by 1. Writing the load word or the control word restarts the divider.
- R4: With control bit 0 set (one-shot), a channel whose count is zero keeps a count of zero and never sets its raw flag again until a new load is written.
- R5: A write to word 0 (load) sets both the limit and the count. A write to word 6 (background load) sets only the limit. A read of word 0 or word 6 returns the limit.
- R6: Word 4 reads the raw flag in bit 0. Word 5 reads the raw flag ANDed with control bit 5. Any write to word 3 clears the raw flag.
- R7: After reset, each channel reads control 0x20, count 0xFFFFFFFF, limit 0 and raw flag 0, and all interrupt lines are low.
- R8: Interrupt line n is high exactly when channel n has its raw flag set and control bit 5 set.
- R9: Word 1 reads the live count, and writes to word 1 are ignored. A write to word 2 replaces the control byte but keeps the current count.
- R10: The raw flag is set on the counter step that makes the count zero. If a clear write lands in the same cycle as that step, the flag is still set.
- R11: The word address is split into two fields. Bits [7:6] select the channel and bits [5:0] select the word within that channel's window. A channel index of 3 or above reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_word_addr | input | 8 | Word address: channel index in [7:6], word in [5:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_word_addr |
| tick_en | input | 3 | Per-channel count enable |
| irq | output | 3 | Per-channel interrupt request |

## Verification
The hardest case to reach is a counter step that makes the count zero in the same cycle as a clear write. The bench reaches it as follows:
- It loads a count of 1 with the divide-by-1 setting.
- In one cycle it drives both the tick and the clear write, then reads the raw flag.

The divide-by-256 boundary needs long tick bursts. The bench checks the count after 255 ticks, when it must still be unchanged, and again after the 256th tick. A one-shot channel sitting at zero gets a further burst of ticks after its flag is cleared, to show that no new event appears.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

  localparam int DATA_W = 32;

  // word offsets inside one channel window
  localparam logic [5:0] WD_LOAD   = 6'd0;
  localparam logic [5:0] WD_VALUE  = 6'd1;
  localparam logic [5:0] WD_CTRL   = 6'd2;
  localparam logic [5:0] WD_CLEAR  = 6'd3;
  localparam logic [5:0] WD_RAW    = 6'd4;
  localparam logic [5:0] WD_MASKED = 6'd5;
  localparam logic [5:0] WD_BGLOAD = 6'd6;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  typedef struct packed {
    logic       enable;    // bit 7
    logic       periodic;  // bit 6
    logic       irq_en;    // bit 5
    logic       spare;     // bit 4
    logic [1:0] divsel;    // bits 3:2
    logic       size32;    // bit 1
    logic       oneshot;   // bit 0
  } ctrl_t;

  // log2 of the tick divider picked by the divider select field
  function automatic logic [3:0] div_shift(input logic [1:0] sel);
    case (sel)
      2'b01:   div_shift = 4'd4;
      2'b10:   div_shift = 4'd8;
      default: div_shift = 4'd0;
    endcase
  endfunction

  // count after one step
  function automatic logic [DATA_W-1:0] step_value(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] lim,
      input logic              periodic,
      input logic              size32);
    if (cur != '0)
      step_value = cur - 1'b1;
    else if (periodic)
      step_value = lim;
    else if (size32)
      step_value = {DATA_W{1'b1}};
    else
      step_value = DATA_W'(16'hFFFF);
  endfunction

endpackage

// File: rtl/pit_prescaler.sv
`timescale 1ns/1ps
module pit_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic       tick,
  input  logic [3:0] shift,
  output logic       step
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] term;

  assign term = PRE_W'((32'd1 << shift) - 32'd1);
  assign step = run && tick && !restart && (cnt_q == term);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (run && tick)      cnt_q <= step ? '0 : cnt_q + 1'b1;
  end

  // R3: the divider phase never passes the selected terminal value
  p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (cnt_q <= term));

endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
#(
  parameter int WORD_W = 6,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] limit_q;
  logic              raw_q;

  // named internal events
  logic we_load, we_bg, we_ctrl, we_clear, we_value;
  logic halted, run, step, zero_hit;
  logic [DATA_W-1:0] next_val;

  assign we_load  = wr_en && (word == WORD_W'(WD_LOAD));
  assign we_bg    = wr_en && (word == WORD_W'(WD_BGLOAD));
  assign we_ctrl  = wr_en && (word == WORD_W'(WD_CTRL));
  assign we_clear = wr_en && (word == WORD_W'(WD_CLEAR));
  assign we_value = wr_en && (word == WORD_W'(WD_VALUE));

  assign halted   = ctrl_q.oneshot && (count_q == '0);
  assign run      = ctrl_q.enable && !halted;
  assign next_val = step_value(count_q, limit_q, ctrl_q.periodic, ctrl_q.size32);
  assign zero_hit = step && (next_val == '0);

  pit_prescaler #(.PRE_W(PRE_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (we_load || we_ctrl),
    .run     (run),
    .tick    (tick),
    .shift   (div_shift(ctrl_q.divsel)),
    .step    (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_t'(CTRL_RESET);
      count_q <= {DATA_W{1'b1}};
      limit_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (we_ctrl)             ctrl_q  <= ctrl_t'(wdata[7:0]);
      if (we_load || we_bg)    limit_q <= wdata;
      if (we_load)             count_q <= wdata;
      else if (step)           count_q <= next_val;
      if (zero_hit)            raw_q   <= 1'b1;
      else if (we_clear)       raw_q   <= 1'b0;
    end
  end

  assign irq = raw_q && ctrl_q.irq_en;

  always_comb begin
    rdata = '0;
    case (word)
      WORD_W'(WD_LOAD), WORD_W'(WD_BGLOAD): rdata = limit_q;
      WORD_W'(WD_VALUE):  rdata = count_q;
      WORD_W'(WD_CTRL):   rdata = DATA_W'(ctrl_q);
      WORD_W'(WD_RAW):    rdata = DATA_W'(raw_q);
      WORD_W'(WD_MASKED): rdata = DATA_W'(raw_q && ctrl_q.irq_en);
      default:            rdata = '0;
    endcase
  end

  // R1: a disabled channel keeps its count unless loaded
  p_hold_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.enable && !we_load) |=> (count_q == $past(count_q)));

  // R2: free-running expiry wraps by size
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q == '0 && !ctrl_q.periodic) |=>
      (count_q == ($past(ctrl_q.size32) ? {DATA_W{1'b1}} : DATA_W'(16'hFFFF))));

  // R2: periodic expiry reloads the limit
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q == '0 && ctrl_q.periodic) |=> (count_q == $past(limit_q)));

  // R4: a spent one-shot stays at zero and raises nothing
  p_oneshot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.oneshot && count_q == '0 && !we_load) |=> (count_q == '0));
  p_oneshot_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.oneshot && count_q == '0) |-> !zero_hit);

  // R5: background load leaves the count alone
  p_bg_keeps_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_bg && !step) |=> (count_q == $past(count_q)));

  // R6: a clear without a coincident expiry drops the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_clear && !zero_hit) |=> !raw_q);

  // R8: no request while the interrupt enable is low
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.irq_en |-> !irq);

  // R9: value-word writes do not reach the count
  p_value_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_value && !step) |=> (count_q == $past(count_q)));

  // R10: the raw flag only rises after a step that reached zero
  p_raw_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(zero_hit));

endmodule

// File: rtl/tri_interval_timer.sv
`timescale 1ns/1ps
module tri_interval_timer
  import pit_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int WIN_BITS   = 8,
  parameter int PRE_W      = 8,
  localparam int IDX_W     = $clog2(NUM_TIMERS),
  localparam int WORD_W    = WIN_BITS - 2,
  localparam int ADDR_W    = IDX_W + WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_word_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_TIMERS-1:0] tick_en,
  output logic [NUM_TIMERS-1:0] irq
);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] ch_rdata [NUM_TIMERS];

  assign idx  = bus_word_addr[ADDR_W-1:WORD_W];
  assign word = bus_word_addr[WORD_W-1:0];

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ch
    pit_channel #(.WORD_W(WORD_W), .PRE_W(PRE_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_en[i]),
      .wr_en (bus_wr && (idx == IDX_W'(i))),
      .word  (word),
      .wdata (bus_wdata),
      .rdata (ch_rdata[i]),
      .irq   (irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_TIMERS; i++)
      if (idx == IDX_W'(i)) bus_rdata = ch_rdata[i];
  end

  // R11: unmapped channel index reads zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(idx) >= NUM_TIMERS) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_tri_interval_timer.sv
`timescale 1ns/1ps
module sim_tri_interval_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_word_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  tick_en = '0;
  logic [2:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tri_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word_addr(bus_word_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IQ = 2'd3;
  localparam int NV = 64;
  // {op, byte address (or tick mask), data (or tick count), expected, requirement}
  localparam logic [79:0] VEC [0:NV-1] = '{
    {OP_RD, 10'h008, 32'h0,   32'h20,       4'd7},  // R7
    {OP_RD, 10'h004, 32'h0,   32'hFFFFFFFF, 4'd7},  // R7
    {OP_RD, 10'h204, 32'h0,   32'hFFFFFFFF, 4'd7},  // R7 R11
    {OP_WR, 10'h000, 32'd5,   32'h0,        4'd5},
    {OP_RD, 10'h004, 32'h0,   32'd5,        4'd5},  // R5
    {OP_RD, 10'h018, 32'h0,   32'd5,        4'd5},  // R5
    {OP_WR, 10'h008, 32'hE2,  32'h0,        4'd1},
    {OP_TK, 10'h001, 32'd3,   32'h0,        4'd1},
    {OP_RD, 10'h004, 32'h0,   32'd2,        4'd1},  // R1
    {OP_TK, 10'h001, 32'd2,   32'h0,        4'd10},
    {OP_RD, 10'h010, 32'h0,   32'd1,        4'd10}, // R10
    {OP_RD, 10'h014, 32'h0,   32'd1,        4'd6},  // R6
    {OP_IQ, 10'h000, 32'h0,   32'd1,        4'd8},  // R8
    {OP_TK, 10'h001, 32'd1,   32'h0,        4'd2},
    {OP_RD, 10'h004, 32'h0,   32'd5,        4'd2},  // R2
    {OP_WR, 10'h00C, 32'h0,   32'h0,        4'd6},
    {OP_RD, 10'h010, 32'h0,   32'd0,        4'd6},  // R6
    {OP_WR, 10'h018, 32'd9,   32'h0,        4'd5},
    {OP_RD, 10'h004, 32'h0,   32'd5,        4'd5},  // R5
    {OP_RD, 10'h000, 32'h0,   32'd9,        4'd5},  // R5
    {OP_TK, 10'h001, 32'd6,   32'h0,        4'd5},
    {OP_RD, 10'h004, 32'h0,   32'd9,        4'd5},  // R5
    {OP_WR, 10'h004, 32'h1234,32'h0,        4'd9},
    {OP_RD, 10'h004, 32'h0,   32'd9,        4'd9},  // R9
    {OP_WR, 10'h008, 32'h62,  32'h0,        4'd9},
    {OP_TK, 10'h001, 32'd3,   32'h0,        4'd1},
    {OP_RD, 10'h004, 32'h0,   32'd9,        4'd1},  // R1
    {OP_WR, 10'h008, 32'hE2,  32'h0,        4'd9},
    {OP_TK, 10'h001, 32'd2,   32'h0,        4'd9},
    {OP_RD, 10'h004, 32'h0,   32'd7,        4'd9},  // R9
    {OP_WR, 10'h00C, 32'h0,   32'h0,        4'd6},
    {OP_WR, 10'h100, 32'd2,   32'h0,        4'd11},
    {OP_WR, 10'h108, 32'h80,  32'h0,        4'd11},
    {OP_TK, 10'h002, 32'd3,   32'h0,        4'd2},
    {OP_RD, 10'h104, 32'h0,   32'h0000FFFF, 4'd2},  // R2
    {OP_RD, 10'h110, 32'h0,   32'd1,        4'd6},  // R6
    {OP_RD, 10'h114, 32'h0,   32'd0,        4'd6},  // R6
    {OP_IQ, 10'h000, 32'h0,   32'd0,        4'd8},  // R8
    {OP_WR, 10'h200, 32'd1,   32'h0,        4'd2},
    {OP_WR, 10'h208, 32'h82,  32'h0,        4'd2},
    {OP_TK, 10'h004, 32'd2,   32'h0,        4'd2},
    {OP_RD, 10'h204, 32'h0,   32'hFFFFFFFF, 4'd2},  // R2
    {OP_WR, 10'h200, 32'd2,   32'h0,        4'd4},
    {OP_WR, 10'h208, 32'hA3,  32'h0,        4'd4},
    {OP_WR, 10'h20C, 32'h0,   32'h0,        4'd4},
    {OP_TK, 10'h004, 32'd4,   32'h0,        4'd4},
    {OP_RD, 10'h204, 32'h0,   32'd0,        4'd4},  // R4
    {OP_RD, 10'h210, 32'h0,   32'd1,        4'd10}, // R10
    {OP_IQ, 10'h000, 32'h0,   32'd4,        4'd8},  // R8
    {OP_WR, 10'h20C, 32'h0,   32'h0,        4'd4},
    {OP_TK, 10'h004, 32'd3,   32'h0,        4'd4},
    {OP_RD, 10'h210, 32'h0,   32'd0,        4'd4},  // R4
    {OP_RD, 10'h204, 32'h0,   32'd0,        4'd4},  // R4
    {OP_WR, 10'h100, 32'd3,   32'h0,        4'd3},
    {OP_WR, 10'h108, 32'h84,  32'h0,        4'd3},
    {OP_TK, 10'h002, 32'd15,  32'h0,        4'd3},
    {OP_RD, 10'h104, 32'h0,   32'd3,        4'd3},  // R3
    {OP_TK, 10'h002, 32'd1,   32'h0,        4'd3},
    {OP_RD, 10'h104, 32'h0,   32'd2,        4'd3},  // R3
    {OP_WR, 10'h100, 32'd2,   32'h0,        4'd3},
    {OP_WR, 10'h108, 32'h88,  32'h0,        4'd3},
    {OP_TK, 10'h002, 32'd255, 32'h0,        4'd3},
    {OP_RD, 10'h104, 32'h0,   32'd2,        4'd3},  // R3
    {OP_TK, 10'h002, 32'd1,   32'h0,        4'd3}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word_addr = a[9:2]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_tick(input logic [2:0] m, input int n);
    @(negedge clk);
    tick_en = m;
    repeat (n) @(negedge clk);
    tick_en = '0;
  endtask

  task automatic do_read(input logic [9:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    bus_word_addr = a[9:2];
    #1;
    check(bus_rdata, exp, req);
  endtask

  task automatic do_irq(input logic [2:0] exp, input int req);
    @(negedge clk);
    #1;
    check(32'(irq), 32'(exp), req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_irq(3'b000, 7);  // R7
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][79:78])
        OP_WR: do_write(VEC[i][77:68], VEC[i][67:36]);
        OP_RD: do_read(VEC[i][77:68], VEC[i][35:4], int'(VEC[i][3:0]));
        OP_TK: do_tick(VEC[i][70:68], int'(VEC[i][67:36]));
        default: do_irq(VEC[i][6:4], int'(VEC[i][3:0]));
      endcase
    end
    // R3: 256th tick completes the divide-by-256 period
    do_read(10'h104, 32'd1, 3);
    // R10: expiry and clear write in the same cycle, set wins
    do_write(10'h000, 32'd1);
    @(negedge clk);
    tick_en = 3'b001; bus_wr = 1'b1; bus_word_addr = 8'h03; bus_wdata = '0;
    @(negedge clk);
    tick_en = '0; bus_wr = 1'b0;
    do_read(10'h010, 32'd1, 10);  // R10
    do_read(10'h004, 32'd0, 10);  // R10
    // R11: channel index 3 reads zero
    do_read(10'h308, 32'd0, 11);
    // R7: reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    do_read(10'h008, 32'h20, 7);
    do_read(10'h004, 32'hFFFFFFFF, 7);
    do_read(10'h000, 32'd0, 7);
    do_read(10'h010, 32'd0, 7);
    do_irq(3'b000, 7);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule